// File: doc/BRIEF.md
# Counter Snapshot Capture Buffer

This block keeps a frozen copy of a free-running counter, so that a host can read the count even though the live counter has no read path of its own. Two events copy the count into the held register. The first is the rising edge of an asynchronous zero-mark input. The second is a software strobe that the host writes through a small register write port. Reading the held copy never changes it, so the host can collect the pieces in any order and always gets a coherent value.

A board-mode input picks how the host read port slices the snapshot. It can be read either as byte lanes, each returned in the low byte of the read bus, or as 16-bit halves. A channel-mode input and a write-protect input together can block the software strobe. A capture-valid flag tells the host that a new value is waiting, and reading the most significant piece clears it.

Top module: `snap_capture_buf`

## Requirements
- R1: While `rst` is high at a clock edge, the snapshot clears to zero, and `cap_valid_o` and `rd_valid_o` clear to 0.
- R2: `zmark_i` passes through a two-flop synchronizer. Its rising edge then causes exactly one capture, however long the pulse lasts. If `zmark_i` rises just before clock edge k, the snapshot takes the `count_i` value present at edge k+2.
- R3: A write with `wr_en_i`=1, `wr_addr_i`=3 and `wr_data_i`=16'h0001 is a software strobe. It captures `count_i` at that same clock edge. A write with any other address or data value captures nothing.
- R4: A software strobe has no effect when `hw_acq_mode_i`=1 and `wprot_i`=1. In the other three combinations of these two inputs, it captures normally.
- R5: When a zero-mark capture and a software strobe fall on the same edge, only one capture happens, and it takes the `count_i` value present at that edge.
- R6: With `board_mode_i`=0 (byte lanes), a read with `rd_en_i`=1 and `rd_addr_i`=k returns {8'h00, snapshot[8k+7:8k]} on `rd_data_o` at the next edge. `rd_valid_o` is 1 for that one cycle.
- R7: With `board_mode_i`=1 (halves), `rd_addr_i[0]`=0 returns snapshot[15:0] and `rd_addr_i[0]`=1 returns snapshot[31:16], both one cycle after the read. `rd_addr_i[1]` is ignored in this mode.
- R8: Reads never change the snapshot. Any order of reads, and any repeated read, returns the same data until the next capture.
- R9: `cap_valid_o` rises at the edge of each capture. It falls at the edge of a read of the most significant piece: address 3 in byte mode, or address 1 in half mode. Other reads leave it unchanged. When a capture and a clearing read fall on the same edge, the capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| count_i | input | 32 | Live count from the counter |
| zmark_i | input | 1 | Asynchronous zero-mark pulse |
| board_mode_i | input | 1 | Read slicing: 0 = byte lanes, 1 = 16-bit halves |
| hw_acq_mode_i | input | 1 | Channel is in hardware-assisted position-acquisition mode |
| wprot_i | input | 1 | Channel write protection is enabled |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 2 | Host write address |
| wr_data_i | input | 16 | Host write data |
| rd_en_i | input | 1 | Host read request |
| rd_addr_i | input | 2 | Host read address (lane or half) |
| rd_data_o | output | 16 | Registered read data |
| rd_valid_o | output | 1 | Read data valid, one cycle after a request |
| cap_valid_o | output | 1 | A fresh snapshot is waiting |

## Verification
Two things can share one clock edge. A synchronized zero-mark edge can coincide with a software strobe, and a capture can coincide with the read that clears the valid flag. The bench raises `zmark_i` so that its detected edge falls on the same edge as a strobe write while `count_i` steps every cycle. The read-back must equal the count present at that shared edge and no later value. The bench also issues a strobe and a most-significant read in the same cycle and expects `cap_valid_o` to stay high.

// File: rtl/snapbuf_pkg.sv
package snapbuf_pkg;
  typedef enum logic {
    BM_BYTE = 1'b0,
    BM_HALF = 1'b1
  } bmode_e;
endpackage

// File: rtl/zmark_sync.sv
module zmark_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  // stages 0..STAGES-1 synchronize, stage STAGES holds the previous value
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-1:0], async_i};
  end

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

  AST_ONE_RISE_PER_EDGE: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o); // R2
endmodule

// File: rtl/strobe_gate.sv
module strobe_gate #(
  parameter int          WR_AW    = 2,
  parameter int          BUS_W    = 16,
  parameter int unsigned STB_ADDR = 3,
  parameter int unsigned STB_CODE = 1
) (
  input  logic             wr_en_i,
  input  logic [WR_AW-1:0] wr_addr_i,
  input  logic [BUS_W-1:0] wr_data_i,
  input  logic             hw_acq_mode_i,
  input  logic             wprot_i,
  output logic             strobe_o
);
  logic hit;
  logic locked;

  always_comb begin
    hit      = wr_en_i && (wr_addr_i == WR_AW'(STB_ADDR)) && (wr_data_i == BUS_W'(STB_CODE));
    locked   = hw_acq_mode_i && wprot_i;
    strobe_o = hit && !locked;
  end
endmodule

// File: rtl/snap_store.sv
module snap_store #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             zrise_i,
  input  logic             strobe_i,
  input  logic             msb_rd_i,
  output logic [CNT_W-1:0] snap_o,
  output logic             valid_o
);
  logic capture;
  assign capture = zrise_i | strobe_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      if (capture) snap_o <= cnt_i;
      if (capture)       valid_o <= 1'b1;
      else if (msb_rd_i) valid_o <= 1'b0;
    end
  end

  AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (rst)
    capture |=> (snap_o == $past(cnt_i))); // R5
  AST_HOLD_WITHOUT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(snap_o)); // R8
  AST_VALID_SET: assert property (@(posedge clk) disable iff (rst)
    capture |=> valid_o); // R9
  AST_VALID_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (msb_rd_i && !capture) |=> !valid_o); // R9
endmodule

// File: rtl/read_port.sv
module read_port
  import snapbuf_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int BUS_W = 16,
  localparam int NB   = CNT_W / 8,
  localparam int NW   = CNT_W / BUS_W,
  localparam int RAW  = $clog2(NB),
  localparam int WAW  = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] snap_i,
  input  bmode_e           mode_i,
  input  logic             rd_en_i,
  input  logic [RAW-1:0]   rd_addr_i,
  output logic [BUS_W-1:0] rd_data_o,
  output logic             rd_valid_o,
  output logic             msb_rd_o
);
  logic [7:0]       lane_b [NB];
  logic [BUS_W-1:0] lane_w [NW];
  logic [BUS_W-1:0] sel;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign lane_b[b] = snap_i[8*b +: 8];
  end
  for (genvar w = 0; w < NW; w++) begin : g_half
    assign lane_w[w] = snap_i[BUS_W*w +: BUS_W];
  end

  always_comb begin
    if (mode_i == BM_HALF) begin
      sel      = lane_w[rd_addr_i[WAW-1:0]];
      msb_rd_o = rd_en_i && (rd_addr_i[WAW-1:0] == WAW'(NW - 1));
    end else begin
      sel      = BUS_W'(lane_b[rd_addr_i]);
      msb_rd_o = rd_en_i && (rd_addr_i == RAW'(NB - 1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= sel;
    end
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> rd_valid_o); // R6
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_o && $past(mode_i == BM_BYTE)) |-> (rd_data_o[BUS_W-1:8] == '0)); // R6
endmodule

// File: rtl/snap_capture_buf.sv
module snap_capture_buf
  import snapbuf_pkg::*;
#(
  parameter int          CNT_W       = 32,
  parameter int          BUS_W       = 16,
  parameter int          WR_AW       = 2,
  parameter int unsigned STB_ADDR    = 3,
  parameter int unsigned STB_CODE    = 1,
  parameter int          SYNC_STAGES = 2,
  localparam int         RAW         = $clog2(CNT_W / 8)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count_i,
  input  logic             zmark_i,
  input  logic             board_mode_i,
  input  logic             hw_acq_mode_i,
  input  logic             wprot_i,
  input  logic             wr_en_i,
  input  logic [WR_AW-1:0] wr_addr_i,
  input  logic [BUS_W-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic [RAW-1:0]   rd_addr_i,
  output logic [BUS_W-1:0] rd_data_o,
  output logic             rd_valid_o,
  output logic             cap_valid_o
);
  logic             zrise;
  logic             sw_strobe;
  logic             msb_rd;
  logic [CNT_W-1:0] snap;
  bmode_e           mode;

  assign mode = bmode_e'(board_mode_i);

  zmark_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (zmark_i),
    .rise_o  (zrise)
  );

  strobe_gate #(
    .WR_AW    (WR_AW),
    .BUS_W    (BUS_W),
    .STB_ADDR (STB_ADDR),
    .STB_CODE (STB_CODE)
  ) u_gate (
    .wr_en_i       (wr_en_i),
    .wr_addr_i     (wr_addr_i),
    .wr_data_i     (wr_data_i),
    .hw_acq_mode_i (hw_acq_mode_i),
    .wprot_i       (wprot_i),
    .strobe_o      (sw_strobe)
  );

  snap_store #(.CNT_W(CNT_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .cnt_i    (count_i),
    .zrise_i  (zrise),
    .strobe_i (sw_strobe),
    .msb_rd_i (msb_rd),
    .snap_o   (snap),
    .valid_o  (cap_valid_o)
  );

  read_port #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .snap_i     (snap),
    .mode_i     (mode),
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o),
    .msb_rd_o   (msb_rd)
  );

  AST_LOCKED_STROBE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (hw_acq_mode_i && wprot_i && wr_en_i && (wr_addr_i == WR_AW'(STB_ADDR)) && !zrise)
      |=> $stable(snap)); // R4
  AST_OPEN_STROBE_CAPTURES: assert property (@(posedge clk) disable iff (rst)
    (!(hw_acq_mode_i && wprot_i) && wr_en_i && (wr_addr_i == WR_AW'(STB_ADDR))
      && (wr_data_i == BUS_W'(STB_CODE))) |=> (snap == $past(count_i))); // R3
endmodule

// File: tb/tb_snap_capture_buf.sv
module tb_snap_capture_buf;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] count_i;
  logic        zmark_i, board_mode_i, hw_acq_mode_i, wprot_i;
  logic        wr_en_i, rd_en_i;
  logic [1:0]  wr_addr_i, rd_addr_i;
  logic [15:0] wr_data_i;
  logic [15:0] rd_data_o;
  logic        rd_valid_o, cap_valid_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  snap_capture_buf dut (
    .clk(clk), .rst(rst), .count_i(count_i), .zmark_i(zmark_i),
    .board_mode_i(board_mode_i), .hw_acq_mode_i(hw_acq_mode_i), .wprot_i(wprot_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o), .cap_valid_o(cap_valid_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); rd_en_i = 1'b1; rd_addr_i = a;
    @(negedge clk); rd_en_i = 1'b0;
    d = rd_data_o;
    chk("R6 rd_valid", {31'b0, rd_valid_o}, 32'd1);
  endtask

  task automatic write(input logic [1:0] a, input logic [15:0] v);
    @(negedge clk); wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = v;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic get_snap(output logic [31:0] v);
    logic [15:0] lo, hi;
    board_mode_i = 1'b1;
    rd(2'd0, lo);
    rd(2'd1, hi);
    v = {hi, lo};
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] s, pat;
    logic [15:0] d;
    logic [31:0] prev;
    rst = 1'b1; count_i = 32'hDEAD_BEEF; zmark_i = 0; board_mode_i = 0;
    hw_acq_mode_i = 0; wprot_i = 0; wr_en_i = 0; rd_en_i = 0;
    wr_addr_i = 0; rd_addr_i = 0; wr_data_i = 0;
    repeat (3) @(negedge clk);
    chk("R1 cap_valid", {31'b0, cap_valid_o}, 0);
    chk("R1 rd_valid", {31'b0, rd_valid_o}, 0);
    rst = 1'b0;
    get_snap(s);
    chk("R1 snapshot", s, 32'h0);

    // R3: strobe captures; wrong address or data does not
    count_i = 32'h1234_5678;
    write(2'd3, 16'h0001);
    chk("R9 valid after strobe", {31'b0, cap_valid_o}, 1);
    board_mode_i = 1'b1;
    rd(2'd0, d);
    chk("R7 low half", {16'b0, d}, 32'h5678);
    chk("R9 valid kept on low read", {31'b0, cap_valid_o}, 1);
    rd(2'd1, d);
    chk("R7 high half", {16'b0, d}, 32'h1234);
    chk("R9 valid cleared on high read", {31'b0, cap_valid_o}, 0);
    count_i = 32'hAAAA_5555;
    write(2'd2, 16'h0001);
    write(2'd3, 16'h0000);
    write(2'd3, 16'h0101);
    get_snap(s);
    chk("R3 non-strobe writes", s, 32'h1234_5678);
    chk("R3 no valid from non-strobe", {31'b0, cap_valid_o}, 0);

    // R6/R8: byte-lane sweep, reads in several orders
    for (int p = 0; p < 6; p++) begin
      pat = 32'h0102_0304 * (p + 1) ^ (32'hF00F_0FF0 >> p);
      count_i = pat;
      write(2'd3, 16'h0001);
      count_i = ~pat;
      board_mode_i = 1'b0;
      for (int k = 0; k < 4; k++) begin
        int a;
        a = (k * (p + 1) + p) % 4;
        rd(a[1:0], d);
        chk("R6 byte lane", {16'b0, d}, {24'b0, pat[8*a +: 8]});
      end
      for (int a = 3; a >= 0; a--) begin
        rd(a[1:0], d);
        chk("R8 reread byte", {16'b0, d}, {24'b0, pat[8*a +: 8]});
      end
      board_mode_i = 1'b1;
      rd(2'd3, d);
      chk("R7 addr bit1 ignored high", {16'b0, d}, {16'b0, pat[31:16]});
      rd(2'd2, d);
      chk("R7 addr bit1 ignored low", {16'b0, d}, {16'b0, pat[15:0]});
    end

    // R4: gating sweep over mode x protect
    prev = 32'h0;
    get_snap(prev);
    for (int g = 0; g < 4; g++) begin
      hw_acq_mode_i = g[1]; wprot_i = g[0];
      pat = 32'h4000_0000 + 32'h0001_1111 * g;
      count_i = pat;
      write(2'd3, 16'h0001);
      get_snap(s);
      if (g == 3) chk("R4 locked strobe ignored", s, prev);
      else        chk("R4 open strobe captures", s, pat);
      prev = s;
    end
    hw_acq_mode_i = 0; wprot_i = 0;

    // R2: long zero-mark pulse, one capture at edge k+2
    count_i = 32'hC0DE_0001;
    @(negedge clk); zmark_i = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R2 no capture before sync", {31'b0, cap_valid_o}, 0);
    @(negedge clk);
    chk("R2 capture after sync", {31'b0, cap_valid_o}, 1);
    count_i = 32'hC0DE_0002;
    repeat (6) @(negedge clk);
    zmark_i = 1'b0;
    repeat (4) @(negedge clk);
    get_snap(s);
    chk("R2 single capture per pulse", s, 32'hC0DE_0001);

    // R5: zero-mark edge and strobe on the same edge, count stepping
    @(negedge clk); count_i = 32'h7000_0000; zmark_i = 1'b1;
    @(negedge clk); count_i = 32'h7000_0001;
    @(negedge clk); count_i = 32'h7000_0002;
    wr_en_i = 1'b1; wr_addr_i = 2'd3; wr_data_i = 16'h0001;
    @(negedge clk); count_i = 32'h7000_0003; wr_en_i = 1'b0;
    @(negedge clk); count_i = 32'h7000_0004; zmark_i = 1'b0;
    repeat (4) @(negedge clk);
    get_snap(s);
    chk("R5 joint capture", s, 32'h7000_0002);

    // R9: capture and clearing read on one edge -> capture wins
    board_mode_i = 1'b1;
    count_i = 32'h0BAD_F00D;
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 2'd3; wr_data_i = 16'h0001;
    rd_en_i = 1'b1; rd_addr_i = 2'd1;
    @(negedge clk); wr_en_i = 1'b0; rd_en_i = 1'b0;
    chk("R9 capture wins over clear", {31'b0, cap_valid_o}, 1);
    board_mode_i = 1'b0;
    rd(2'd2, d);
    chk("R9 byte non-msb keeps valid", {31'b0, cap_valid_o}, 1);
    rd(2'd3, d);
    chk("R9 byte msb clears valid", {31'b0, cap_valid_o}, 0);
    chk("R6 msb byte", {16'b0, d}, 32'h0000_000B);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule